// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the next-state logic and the state register of a microprogrammed control unit for a 16-bit processor. A 6-bit micro-address picks one microinstruction out of a 64-entry control store. Each microinstruction is 49 bits wide. Of these, 39 bits are control bits for the datapath and 10 bits say how the next micro-address is formed. The control word of the current micro-address is driven straight out to the datapath. The datapath itself is not part of this block.

The control store inside the block is small. It holds the three-step instruction fetch, the decode step, the execute steps for add, and and not, the conditional branch, the base-plus-offset load and store sequences, and the two forms of subroutine call. The next address is normally a jump target taken from the microinstruction. A selected condition (memory ready, branch enable, or instruction bit 11) can set one low-order bit of that target. At decode, the next address is instead the instruction opcode itself. A branch-enable flag is computed and stored during decode. It is built from bits 11:9 of the instruction and the processor's N/Z/P condition codes.

The reset input is asynchronous and active low. Its release is synchronised to the clock over two stages. The sequencer therefore leaves the first fetch state on the third rising edge after reset is released.

Top module: `useq_core`

## Requirements
- R1: While reset is active, and for two rising edges after its release, the micro-address is 18. The micro-address then advances on each following rising edge.
- R2: Fetch runs 18 → 33 → 35 → 32. State 33 stays at 33 on every edge where mem_rdy is 0 and moves to 35 on the first edge where mem_rdy is 1.
- R3: State 32 (decode) moves to the address {2'b00, opcode}, where opcode is bits 15:12 of the instruction.
- R4: The branch-enable flag is loaded only in state 32, with (ir_nzp[2]&cc_n)|(ir_nzp[1]&cc_z)|(ir_nzp[0]&cc_p). ir_nzp holds instruction bits 11,10,9. Outside state 32 the flag holds its value. It resets to 0.
- R5: State 0 (branch) moves to 22 when the branch-enable flag is 1 and to 18 when it is 0. State 22 moves to 18.
- R6: States 1, 5 and 9 (add, and, not) each move to 18.
- R7: Load sequence is 6 → 25 → 27 → 18. State 25 waits at 25 until mem_rdy is 1.
- R8: Store sequence is 7 → 23 → 16 → 18. State 16 waits at 16 until mem_rdy is 1.
- R9: State 4 moves to 21 when ir_nzp[2] (instruction bit 11) is 1 and to 20 when it is 0. States 20 and 21 both move to 18.
- R10: Every address not listed in R2–R9 has an all-zero control word and moves to 18.
- R11: Control word bit map: bit0 load MAR, bit1 load MDR, bit2 load IR, bit3 load PC, bit4 write register, bit5 set condition codes, bit6 memory enable, bit7 memory write, bits 9:8 ALU op (00 add, 01 and, 10 not), bit10 load branch enable. All other bits are 0. The bits set in each state are:
  - 18: {0,3}
  - 33: {1,6}
  - 35: {2}
  - 32: {10}
  - 0: none
  - 22: {3}
  - 1: {4,5}, ALU op 00
  - 5: {4,5}, ALU op 01
  - 9: {4,5}, ALU op 10
  - 6: {0}
  - 25: {1,6}
  - 27: {4,5}
  - 7: {0}
  - 23: {1}
  - 16: {6,7}
  - 4: {4}
  - 20: {3}
  - 21: {3}

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Instruction bits 15:12 |
| ir_nzp | input | 3 | Instruction bits 11:9 |
| cc_n | input | 1 | Negative condition code |
| cc_z | input | 1 | Zero condition code |
| cc_p | input | 1 | Positive condition code |
| mem_rdy | input | 1 | Memory access complete |
| state_addr | output | 6 | Current micro-address |
| ctrl_word | output | 39 | Control bits of the current microinstruction |

## Verification
The embedded properties check on every cycle the transitions that can be seen locally:
- the fetch wait and fetch advance;
- the decode jump to the opcode;
- the taken branch;
- the return from the execute states;
- the subroutine-call split on bit 11;
- the branch flag holding its value outside decode.

Only the bench's reference model and its scenarios can show three further things:
- the exact control word in every state;
- that the branch flag is loaded with the right combination of instruction bits and condition codes;
- that every undefined opcode falls back to fetch.

Random memory-ready delays exercise each wait state. A new instruction and new condition codes are applied at every fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W = 6;
  localparam int CTL_W  = 39;
  localparam int OPC_W  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  // next-state condition selector
  typedef enum logic [2:0] {
    COND_NONE = 3'd0,
    COND_RDY  = 3'd1,
    COND_BEN  = 3'd2,
    COND_IR11 = 3'd3
  } cond_e;

  typedef struct packed {
    logic [CTL_W-1:0]  ctl;
    logic              disp;
    cond_e             cnd;
    logic [ADDR_W-1:0] jmp;
  } uinst_t;

  localparam int UI_W = $bits(uinst_t);

  // control bit positions
  localparam int CB_LD_MAR  = 0;
  localparam int CB_LD_MDR  = 1;
  localparam int CB_LD_IR   = 2;
  localparam int CB_LD_PC   = 3;
  localparam int CB_LD_REG  = 4;
  localparam int CB_LD_CC   = 5;
  localparam int CB_MEM_EN  = 6;
  localparam int CB_MEM_WE  = 7;
  localparam int CB_ALU_LO  = 8;
  localparam int CB_LD_BEN  = 10;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_AND = 2'b01;
  localparam logic [1:0] ALU_NOT = 2'b10;

  // well-known micro-addresses
  localparam logic [ADDR_W-1:0] A_BR     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ADD    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_JSR    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_AND    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_LDR    = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_STR    = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_NOT    = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_STWR   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_FETCH  = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] A_JSRB   = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_JSRP   = ADDR_W'(21);
  localparam logic [ADDR_W-1:0] A_BRTK   = ADDR_W'(22);
  localparam logic [ADDR_W-1:0] A_STMDR  = ADDR_W'(23);
  localparam logic [ADDR_W-1:0] A_LDRD   = ADDR_W'(25);
  localparam logic [ADDR_W-1:0] A_LDWB   = ADDR_W'(27);
  localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] A_FRD    = ADDR_W'(33);
  localparam logic [ADDR_W-1:0] A_FIR    = ADDR_W'(35);

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uinst_t            word
);

  function automatic logic [CTL_W-1:0] cb(input int pos);
    return CTL_W'(1) << pos;
  endfunction

  function automatic logic [CTL_W-1:0] alu(input logic [1:0] op);
    return CTL_W'(op) << CB_ALU_LO;
  endfunction

  function automatic uinst_t mk(input logic [CTL_W-1:0] c, input logic d,
                                input cond_e k, input logic [ADDR_W-1:0] j);
    uinst_t u;
    u.ctl  = c;
    u.disp = d;
    u.cnd  = k;
    u.jmp  = j;
    return u;
  endfunction

  function automatic uinst_t entry(input int a);
    case (a)
      18:      return mk(cb(CB_LD_MAR) | cb(CB_LD_PC), 1'b0, COND_NONE, A_FRD);
      33:      return mk(cb(CB_LD_MDR) | cb(CB_MEM_EN), 1'b0, COND_RDY, A_FRD);
      35:      return mk(cb(CB_LD_IR), 1'b0, COND_NONE, A_DECODE);
      32:      return mk(cb(CB_LD_BEN), 1'b1, COND_NONE, '0);
      0:       return mk('0, 1'b0, COND_BEN, A_FETCH);
      22:      return mk(cb(CB_LD_PC), 1'b0, COND_NONE, A_FETCH);
      1:       return mk(cb(CB_LD_REG) | cb(CB_LD_CC) | alu(ALU_ADD), 1'b0, COND_NONE, A_FETCH);
      5:       return mk(cb(CB_LD_REG) | cb(CB_LD_CC) | alu(ALU_AND), 1'b0, COND_NONE, A_FETCH);
      9:       return mk(cb(CB_LD_REG) | cb(CB_LD_CC) | alu(ALU_NOT), 1'b0, COND_NONE, A_FETCH);
      6:       return mk(cb(CB_LD_MAR), 1'b0, COND_NONE, A_LDRD);
      25:      return mk(cb(CB_LD_MDR) | cb(CB_MEM_EN), 1'b0, COND_RDY, A_LDRD);
      27:      return mk(cb(CB_LD_REG) | cb(CB_LD_CC), 1'b0, COND_NONE, A_FETCH);
      7:       return mk(cb(CB_LD_MAR), 1'b0, COND_NONE, A_STMDR);
      23:      return mk(cb(CB_LD_MDR), 1'b0, COND_NONE, A_STWR);
      16:      return mk(cb(CB_MEM_EN) | cb(CB_MEM_WE), 1'b0, COND_RDY, A_STWR);
      4:       return mk(cb(CB_LD_REG), 1'b0, COND_IR11, A_JSRB);
      20:      return mk(cb(CB_LD_PC), 1'b0, COND_NONE, A_FETCH);
      21:      return mk(cb(CB_LD_PC), 1'b0, COND_NONE, A_FETCH);
      default: return mk('0, 1'b0, COND_NONE, A_FETCH);
    endcase
  endfunction

  uinst_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign rom[g] = entry(g);
  end

  assign word = rom[addr];

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  uinst_t             ui,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               ben,
  input  logic               rdy,
  input  logic               ir11,
  output logic [ADDR_W-1:0]  nxt
);

  logic [ADDR_W-1:0] cond_or;

  always_comb begin
    cond_or = '0;
    unique case (ui.cnd)
      COND_RDY:  cond_or[1] = rdy;
      COND_BEN:  cond_or[2] = ben;
      COND_IR11: cond_or[0] = ir11;
      default:   cond_or = '0;
    endcase
    if (ui.disp) nxt = {{(ADDR_W-OPC_W){1'b0}}, opcode};
    else         nxt = ui.jmp | cond_or;
  end

endmodule

// File: rtl/useq_ben.sv
module useq_ben (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [2:0] ir_nzp,
  input  logic       cc_n,
  input  logic       cc_z,
  input  logic       cc_p,
  output logic       ben
);

  logic ben_d, ben_q;

  always_comb begin
    ben_d = ben_q;
    if (ld) ben_d = |(ir_nzp & {cc_n, cc_z, cc_p});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ben_q <= 1'b0;
    else        ben_q <= ben_d;
  end

  assign ben = ben_q;

  AST_BEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ben == $past(ben)); // R4

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [2:0]        ir_nzp,
  input  logic              cc_n,
  input  logic              cc_z,
  input  logic              cc_p,
  input  logic              mem_rdy,
  output logic [ADDR_W-1:0] state_addr,
  output logic [CTL_W-1:0]  ctrl_word
);

  // reset release synchroniser
  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q = rs_q[RST_STAGES-1];

  logic [ADDR_W-1:0] state_q, state_d, nxt;
  uinst_t            uw;
  logic              ben;

  useq_store u_store (
    .addr (state_q),
    .word (uw)
  );

  useq_ben u_ben (
    .clk    (clk),
    .rst_n  (rst_q),
    .ld     (uw.ctl[CB_LD_BEN]),
    .ir_nzp (ir_nzp),
    .cc_n   (cc_n),
    .cc_z   (cc_z),
    .cc_p   (cc_p),
    .ben    (ben)
  );

  useq_next u_next (
    .ui     (uw),
    .opcode (opcode),
    .ben    (ben),
    .rdy    (mem_rdy),
    .ir11   (ir_nzp[2]),
    .nxt    (nxt)
  );

  always_comb state_d = nxt;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) state_q <= A_FETCH;
    else        state_q <= state_d;
  end

  assign state_addr = state_q;
  assign ctrl_word  = uw.ctl;

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_q)
    state_q == A_FETCH |=> state_q == A_FRD); // R2
  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == A_FRD && !mem_rdy) |=> state_q == A_FRD); // R2
  AST_DECODE_JUMP: assert property (@(posedge clk) disable iff (!rst_q)
    state_q == A_DECODE |=> state_q == {{(ADDR_W-OPC_W){1'b0}}, $past(opcode)}); // R3
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == A_BR && ben) |=> state_q == A_BRTK); // R5
  AST_EXEC_RETURN: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == A_ADD || state_q == A_AND || state_q == A_NOT) |=> state_q == A_FETCH); // R6
  AST_JSR_SPLIT: assert property (@(posedge clk) disable iff (!rst_q)
    state_q == A_JSR |=> state_q == {A_JSRB[ADDR_W-1:1], $past(ir_nzp[2])}); // R9

endmodule

// File: tb/useq_core_test.sv
module useq_core_test;

  localparam int PERIOD = 10;
  localparam int NCYC   = 4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [2:0]  ir_nzp;
  logic        cc_n, cc_z, cc_p;
  logic        mem_rdy;
  logic [5:0]  state_addr;
  logic [38:0] ctrl_word;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  useq_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .ir_nzp     (ir_nzp),
    .cc_n       (cc_n),
    .cc_z       (cc_z),
    .cc_p       (cc_p),
    .mem_rdy    (mem_rdy),
    .state_addr (state_addr),
    .ctrl_word  (ctrl_word)
  );

  // behavioural reference model
  int m_s    = 18;
  int m_prev = 18;
  int m_ben  = 0;
  int m_rel  = 0;

  function automatic int model_next(int s);
    case (s)
      18: return 33;
      33: return mem_rdy ? 35 : 33;
      35: return 32;
      32: return int'(opcode);
      0:  return (m_ben != 0) ? 22 : 18;
      6:  return 25;
      25: return mem_rdy ? 27 : 25;
      7:  return 23;
      23: return 16;
      16: return mem_rdy ? 18 : 16;
      4:  return ir_nzp[2] ? 21 : 20;
      default: return 18;
    endcase
  endfunction

  function automatic logic [38:0] exp_ctl(int s);
    logic [38:0] c = '0;
    case (s)
      18: begin c[0] = 1; c[3] = 1; end
      33: begin c[1] = 1; c[6] = 1; end
      35: c[2] = 1;
      32: c[10] = 1;
      22: c[3] = 1;
      1:  begin c[4] = 1; c[5] = 1; end
      5:  begin c[4] = 1; c[5] = 1; c[9:8] = 2'b01; end
      9:  begin c[4] = 1; c[5] = 1; c[9:8] = 2'b10; end
      6:  c[0] = 1;
      25: begin c[1] = 1; c[6] = 1; end
      27: begin c[4] = 1; c[5] = 1; end
      7:  c[0] = 1;
      23: c[1] = 1;
      16: begin c[6] = 1; c[7] = 1; end
      4:  c[4] = 1;
      20, 21: c[3] = 1;
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic string tag_of(int prev);
    case (prev)
      18, 33, 35: return "R2";
      32:         return "R3";
      0:          return "R4 R5";
      22:         return "R5";
      1, 5, 9:    return "R6";
      6, 25, 27:  return "R7";
      7, 23, 16:  return "R8";
      4, 20, 21:  return "R9";
      default:    return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 18; m_prev = 18; m_ben = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      if (m_s == 32) m_ben = ((ir_nzp[2] & cc_n) | (ir_nzp[1] & cc_z) | (ir_nzp[0] & cc_p)) ? 1 : 0;
      m_prev = m_s;
      m_s    = model_next(m_s);
    end
  end

  task automatic check_state(string tag);
    total++;
    if (int'(state_addr) != m_s) begin
      bad++;
      $display("FAIL %s state_addr actual=%0d expected=%0d (from %0d)", tag, state_addr, m_s, m_prev);
    end
  endtask

  task automatic check_ctl(string tag);
    total++;
    if (ctrl_word !== exp_ctl(m_s)) begin
      bad++;
      $display("FAIL %s ctrl_word at state %0d actual=%h expected=%h", tag, m_s, ctrl_word, exp_ctl(m_s));
    end
  endtask

  int op_k = 0;

  task automatic new_instr();
    opcode = 4'(op_k % 16);
    if (op_k >= 32) opcode = 4'($urandom_range(0, 15));
    op_k++;
    ir_nzp = 3'($urandom_range(0, 7));
    {cc_n, cc_z, cc_p} = 3'($urandom_range(0, 7));
  endtask

  initial begin
    rst_n = 1'b1; opcode = '0; ir_nzp = '0;
    cc_n = 0; cc_z = 0; cc_p = 0; mem_rdy = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1");  // held at fetch in reset
    check_ctl("R1 R11");
    new_instr();
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");  // first synchroniser edge
    @(negedge clk);
    check_state("R1");  // second synchroniser edge
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      check_state(tag_of(m_prev));
      check_ctl("R11");
      mem_rdy = ($urandom_range(0, 7) < 3);
      if (m_s == 18) new_instr();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule